// File: doc/BRIEF.md
# Clock-Domain Register Write Bridge with Per-Register Busy Flags

This block moves software writes from a fast system-clock register bus into a slow real-time clock domain for four timer registers: an 8-bit control register and three 16-bit registers (count, period and compare). Each register has its own transfer channel. A busy flag for each channel is visible in the system domain. It rises when a write is accepted and falls only after the real-time side has applied the value and its acknowledgement has crossed back. Software polls the flag before writing the same register again.

On the system side the block takes a one-cycle write strobe, a 3-bit byte address and a data byte. A 16-bit register is written as two bytes. The low byte is only staged in a holding register. Writing the high byte launches the whole 16-bit word as one unit. On the real-time side the block presents the current value of each register together with a one-cycle load strobe, which downstream counter logic uses to pick up a new value. Each channel crosses the clocks with a toggle request and a toggle acknowledge, and each toggle passes through a two-flop synchronizer.

Top module: `rtc_reg_sync`

## Requirements
- R1: After reset every busy bit and every load strobe is 0, and the real-time outputs read control 0x00, count 0x0000, compare 0x0000 and period 0xFFFF.
- R2: Byte addresses are: control at 0, count low/high at 2/3, period low/high at 4/5, compare low/high at 6/7. A write to address 1 is ignored: no busy bit rises and no output changes.
- R3: The busy vector is ordered control bit 0, count bit 1, period bit 2, compare bit 3. An accepted launching write (control byte or a high byte) sets its busy bit from the clock edge that takes the write.
- R4: A write to a 16-bit register's low byte only stages that byte. Its busy bit stays 0 and its output is unchanged. The following high-byte write transfers {high byte, last staged low byte} as one word, and the staged byte persists across transfers.
- R5: A launched value reaches the real-time output at the third rising real-time edge after the system edge that took the write. The output still holds the old value after the second edge.
- R6: The load strobe of a channel is high for exactly one real-time cycle, beginning at the edge where the value changes. Only that channel's strobe rises, and the value of a channel changes only when its strobe is high.
- R7: A busy bit stays 1 until the second rising system edge after the real-time edge that applied the value, and it is 0 from that edge on.
- R8: A launching write to a register whose busy bit is 1 is ignored. The value in flight is delivered unchanged.
- R9: A low-byte write to a register whose busy bit is 1 is ignored, and the previously staged low byte is kept.
- R10: The channels are independent. Writes to different registers in consecutive cycles are all busy at once, and each delivers its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System register bus clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset, system domain |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 3 | Byte address of the write |
| wr_data | input | 8 | Write data byte |
| busy | output | 4 | Per-register transfer in progress (ctrl, cnt, per, cmp) |
| rtc_clk | input | 1 | Real-time counter clock |
| rtc_rst_n | input | 1 | Asynchronous active-low reset, real-time domain |
| rtc_ctrl | output | 8 | Control value applied in the real-time domain |
| rtc_cnt | output | 16 | Count value applied in the real-time domain |
| rtc_per | output | 16 | Period value applied in the real-time domain |
| rtc_cmp | output | 16 | Compare value applied in the real-time domain |
| rtc_load | output | 4 | One-cycle strobe per register when its value is applied |

## Verification
The bench runs two clocks that never share an edge. It counts real-time edges from the write, so it can detect a design whose value lands one edge early, or whose busy flag drops before the acknowledgement is back. That second fault would let software overwrite a word still in flight. Back-to-back writes to a busy register go after a launch path that forgets to gate on busy: such a design would toggle the request twice, so the value would be lost or the flag would clear too early. Low-byte-only writes, and low writes that arrive during a transfer, expose a design that transfers the word on the wrong byte or corrupts the staged half. Concurrent writes to two channels catch a shared synchronizer, which would drop or delay one of them.

// File: rtl/rsync_pkg.sv
package rsync_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int NUM_CH = 4;
    localparam int ADDR_W = 3;

    // Channel order is also the busy-bit order seen by software.
    typedef enum logic [1:0] {
        CH_CTRL = 2'd0,
        CH_CNT  = 2'd1,
        CH_PER  = 2'd2,
        CH_CMP  = 2'd3
    } chan_e;

    function automatic int chan_width(input int ch);
        return (ch == int'(CH_CTRL)) ? BYTE_W : WORD_W;
    endfunction

    function automatic logic [WORD_W-1:0] chan_reset(input int ch);
        return (ch == int'(CH_PER)) ? {WORD_W{1'b1}} : {WORD_W{1'b0}};
    endfunction

endpackage

// File: rtl/rsync_bitsync.sv
module rsync_bitsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rsync_sys_port.sv
module rsync_sys_port
    import rsync_pkg::*;
#(
    parameter int                W   = WORD_W,
    parameter logic [WORD_W-1:0] RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_i,
    input  logic              commit_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic [W-1:0]      hold_o,
    output logic              busy_o
);
    typedef struct packed {
        logic              req;
        logic [BYTE_W-1:0] stage;
        logic [W-1:0]      hold;
    } sys_st_t;

    sys_st_t      st_d, st_q;
    logic [W-1:0] word_w;

    if (W == WORD_W) begin : g_wide
        assign word_w = {wdata_i, st_q.stage};
    end else begin : g_narrow
        assign word_w = wdata_i;
    end

    always_comb begin
        st_d   = st_q;
        busy_o = st_q.req ^ ack_i;
        if (!busy_o) begin
            if (stage_i) begin
                st_d.stage = wdata_i;
            end
            if (commit_i) begin
                st_d.hold = word_w;
                st_d.req  = ~st_q.req;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.req   <= 1'b0;
            st_q.stage <= '0;
            st_q.hold  <= RST[W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o  = st_q.req;
    assign hold_o = st_q.hold;
endmodule

// File: rtl/rsync_rtc_port.sv
module rsync_rtc_port
    import rsync_pkg::*;
#(
    parameter int                W   = WORD_W,
    parameter logic [WORD_W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_i,
    input  logic [W-1:0] hold_i,
    output logic         ack_o,
    output logic [W-1:0] val_o,
    output logic         load_o
);
    typedef struct packed {
        logic         seen;
        logic         load;
        logic [W-1:0] val;
    } rtc_st_t;

    rtc_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        // hold_i is quiet while the request toggle is in flight.
        if (req_i != st_q.seen) begin
            st_d.seen = req_i;
            st_d.val  = hold_i;
            st_d.load = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.seen <= 1'b0;
            st_q.load <= 1'b0;
            st_q.val  <= RST[W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o  = st_q.seen;
    assign val_o  = st_q.val;
    assign load_o = st_q.load;
endmodule

// File: rtl/rtc_reg_sync.sv
module rtc_reg_sync
    import rsync_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [NUM_CH-1:0] busy,
    input  logic              rtc_clk,
    input  logic              rtc_rst_n,
    output logic [BYTE_W-1:0] rtc_ctrl,
    output logic [WORD_W-1:0] rtc_cnt,
    output logic [WORD_W-1:0] rtc_per,
    output logic [WORD_W-1:0] rtc_cmp,
    output logic [NUM_CH-1:0] rtc_load
);
    localparam int IDX_W = ADDR_W - 1;

    logic [IDX_W-1:0] wr_idx;
    logic             wr_hi;

    assign wr_idx = wr_addr[ADDR_W-1:1];
    assign wr_hi  = wr_addr[0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int                CW = chan_width(c);
        localparam logic [WORD_W-1:0] RV = chan_reset(c);
        localparam logic [IDX_W-1:0]  CI = IDX_W'(c);

        logic          stage_w, commit_w;
        logic          req_t, req_s, ack_t, ack_s, load_w, busy_w;
        logic [CW-1:0] hold_w, val_w;

        if (c == int'(CH_CTRL)) begin : g_dec_byte
            assign stage_w  = 1'b0;
            assign commit_w = wr_en && (wr_idx == CI) && !wr_hi;
        end else begin : g_dec_word
            assign stage_w  = wr_en && (wr_idx == CI) && !wr_hi;
            assign commit_w = wr_en && (wr_idx == CI) && wr_hi;
        end

        rsync_sys_port #(.W(CW), .RST(RV)) u_sys (
            .clk      (sys_clk),
            .rst_n    (sys_rst_n),
            .stage_i  (stage_w),
            .commit_i (commit_w),
            .wdata_i  (wr_data),
            .ack_i    (ack_s),
            .req_o    (req_t),
            .hold_o   (hold_w),
            .busy_o   (busy_w)
        );

        rsync_bitsync #(.STAGES(SYNC_STAGES)) u_req_sync (
            .clk   (rtc_clk),
            .rst_n (rtc_rst_n),
            .d_i   (req_t),
            .q_o   (req_s)
        );

        rsync_rtc_port #(.W(CW), .RST(RV)) u_rtc (
            .clk    (rtc_clk),
            .rst_n  (rtc_rst_n),
            .req_i  (req_s),
            .hold_i (hold_w),
            .ack_o  (ack_t),
            .val_o  (val_w),
            .load_o (load_w)
        );

        rsync_bitsync #(.STAGES(SYNC_STAGES)) u_ack_sync (
            .clk   (sys_clk),
            .rst_n (sys_rst_n),
            .d_i   (ack_t),
            .q_o   (ack_s)
        );

        assign busy[c]     = busy_w;
        assign rtc_load[c] = load_w;

        if (c == int'(CH_CTRL)) begin : g_out_ctrl
            assign rtc_ctrl = val_w;
        end else if (c == int'(CH_CNT)) begin : g_out_cnt
            assign rtc_cnt = val_w;
        end else if (c == int'(CH_PER)) begin : g_out_per
            assign rtc_per = val_w;
        end else begin : g_out_cmp
            assign rtc_cmp = val_w;
        end
    end
endmodule

// File: rtl/rsync_chk.sv
module rsync_chk
    import rsync_pkg::*;
(
    input logic              sys_clk,
    input logic              sys_rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [NUM_CH-1:0] busy,
    input logic              rtc_clk,
    input logic              rtc_rst_n,
    input logic [BYTE_W-1:0] rtc_ctrl,
    input logic [WORD_W-1:0] rtc_cnt,
    input logic [WORD_W-1:0] rtc_per,
    input logic [WORD_W-1:0] rtc_cmp,
    input logic [NUM_CH-1:0] rtc_load
);
    logic [WORD_W-1:0] vals [NUM_CH];

    assign vals[0] = {{(WORD_W-BYTE_W){1'b0}}, rtc_ctrl};
    assign vals[1] = rtc_cnt;
    assign vals[2] = rtc_per;
    assign vals[3] = rtc_cmp;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        localparam logic [ADDR_W-1:0] LA = ADDR_W'(2 * c);
        localparam logic [ADDR_W-1:0] CA = (c == 0) ? '0 : ADDR_W'(2 * c + 1);

        // R3
        busy_set_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
            (wr_en && wr_addr == CA && !busy[c]) |=> busy[c]);

        // R6
        load_pulse_chk: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
            rtc_load[c] |=> !rtc_load[c]);

        // R6
        value_gate_chk: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
            !$stable(vals[c]) |-> rtc_load[c]);

        if (c != 0) begin : g_word
            // R4
            stage_quiet_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
                (wr_en && wr_addr == LA && !busy[c]) |=> !busy[c]);
        end
    end
endmodule

bind rtc_reg_sync rsync_chk u_chk (
    .sys_clk   (sys_clk),
    .sys_rst_n (sys_rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .busy      (busy),
    .rtc_clk   (rtc_clk),
    .rtc_rst_n (rtc_rst_n),
    .rtc_ctrl  (rtc_ctrl),
    .rtc_cnt   (rtc_cnt),
    .rtc_per   (rtc_per),
    .rtc_cmp   (rtc_cmp),
    .rtc_load  (rtc_load)
);

// File: tb/sim_rtc_reg_sync.sv
`timescale 1ns/100ps
module sim_rtc_reg_sync;
    logic        sys_clk = 1'b0, rtc_clk = 1'b0;
    logic        sys_rst_n = 1'b0, rtc_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  busy, rtc_load;
    logic [7:0]  rtc_ctrl;
    logic [15:0] rtc_cnt, rtc_per, rtc_cmp;

    int checks = 0, errors = 0, rtc_edges = 0, n_w = 0;
    logic [15:0] exp_v [4];
    logic [7:0]  lo_sh [4];

    rtc_reg_sync u0 (.*);

    always #10 sys_clk = ~sys_clk;   // 50 MHz
    always #33 rtc_clk = ~rtc_clk;   // edges never meet system edges
    always @(posedge rtc_clk) rtc_edges <= rtc_edges + 1;

    function automatic logic [15:0] get_val(input int ch);
        case (ch)
            0: return {8'h00, rtc_ctrl};
            1: return rtc_cnt;
            2: return rtc_per;
            default: return rtc_cmp;
        endcase
    endfunction

    function automatic logic [2:0] hi_addr(input int ch);
        return (ch == 0) ? 3'd0 : 3'(2 * ch + 1);
    endfunction

    function automatic logic [15:0] launch_word(input int ch, input logic [7:0] hi);
        return (ch == 0) ? {8'h00, hi} : {hi, lo_sh[ch]};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic pulse(input logic [2:0] a, input logic [7:0] d);
        @(negedge sys_clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge sys_clk);
        n_w = rtc_edges;
        @(negedge sys_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy !== 4'b0 && n < 400) begin
            @(negedge sys_clk);
            n++;
        end
        check("R7 busy drains", {12'h0, busy}, 16'h0);
    endtask

    // Launch a high/control byte and check every timed step of its transfer.
    task automatic timed_commit(input int ch, input logic [7:0] hi);
        logic [15:0] nv;
        nv = launch_word(ch, hi);
        pulse(hi_addr(ch), hi);
        check("R3 busy set", 16'(busy[ch]), 16'h1);
        wait (rtc_edges == n_w + 2);
        @(negedge sys_clk);
        check("R5 old value at second edge", get_val(ch), exp_v[ch]);
        check("R6 no strobe yet", 16'(rtc_load), 16'h0);
        wait (rtc_edges == n_w + 3);
        @(posedge sys_clk);
        @(negedge sys_clk);
        check("R5 new value at third edge", get_val(ch), nv);
        check("R6 single strobe", 16'(rtc_load), 16'(4'b1 << ch));
        check("R7 busy held", 16'(busy[ch]), 16'h1);
        @(posedge sys_clk);
        @(negedge sys_clk);
        check("R7 busy clear", 16'(busy[ch]), 16'h0);
        wait (rtc_edges == n_w + 4);
        @(negedge sys_clk);
        check("R6 strobe ends", 16'(rtc_load), 16'h0);
        exp_v[ch] = nv;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 4; i++) begin
            lo_sh[i] = 8'h00;
            exp_v[i] = (i == 2) ? 16'hFFFF : 16'h0000;
        end
        #200;
        sys_rst_n = 1'b1; rtc_rst_n = 1'b1;
        @(negedge sys_clk);
        // R1 reset state
        check("R1 busy", {12'h0, busy}, 16'h0);
        check("R1 load", {12'h0, rtc_load}, 16'h0);
        for (int i = 0; i < 4; i++) check("R1 value", get_val(i), exp_v[i]);

        // R2 control byte at address 0
        timed_commit(0, 8'hA5);
        // R2 address 1 is ignored
        pulse(3'd1, 8'h3C);
        check("R2 addr1 no busy", {12'h0, busy}, 16'h0);
        repeat (20) @(negedge sys_clk);
        check("R2 addr1 no change", get_val(0), exp_v[0]);

        // R4 low byte only stages
        pulse(3'd4, 8'h12);
        lo_sh[2] = 8'h12;
        check("R4 low no busy", {12'h0, busy}, 16'h0);
        repeat (20) @(negedge sys_clk);
        check("R4 low no change", get_val(2), 16'hFFFF);
        timed_commit(2, 8'h34);
        check("R4 word joined", get_val(2), 16'h3412);

        // R8 launch while busy is ignored
        pulse(3'd6, 8'h11);
        lo_sh[3] = 8'h11;
        pulse(3'd7, 8'hA1);
        pulse(3'd7, 8'hB2);
        check("R8 still busy", 16'(busy[3]), 16'h1);
        wait_idle();
        exp_v[3] = 16'hA111;
        check("R8 first value kept", get_val(3), 16'hA111);

        // R9 low write while busy is ignored
        pulse(3'd2, 8'h55);
        pulse(3'd3, 8'h66);
        pulse(3'd2, 8'h77);
        wait_idle();
        check("R9 first word", get_val(1), 16'h6655);
        lo_sh[1] = 8'h55;
        pulse(3'd3, 8'h88);
        wait_idle();
        exp_v[1] = 16'h8855;
        check("R9 staged low kept", get_val(1), 16'h8855);

        // R10 two channels in flight together
        pulse(3'd0, 8'h5A);
        pulse(3'd7, 8'hC3);
        check("R10 both busy", {12'h0, busy}, 16'h0009);
        wait_idle();
        exp_v[0] = 16'h005A;
        exp_v[3] = 16'hC311;
        check("R10 ctrl", get_val(0), exp_v[0]);
        check("R10 cmp", get_val(3), exp_v[3]);

        // Random sequence of staged and launched writes
        for (int k = 0; k < 60; k++) begin
            int ch;
            logic [31:0] r;
            ch = int'($urandom % 4);
            r = $urandom;
            if (ch != 0 && r[16]) begin
                pulse(3'(2 * ch), r[7:0]);
                lo_sh[ch] = r[7:0];
            end
            timed_commit(ch, r[15:8]);
            for (int i = 0; i < 4; i++) check("R10 others intact", get_val(i), exp_v[i]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule